// File: doc/BRIEF.md
# Page Translation Cache with Round-Robin Refill

This block keeps recently used virtual-to-physical page translations close to the requester, so that a lookup which hits needs no memory reference. A requester presents a virtual address together with a write flag. The block compares the virtual page number against every stored entry in the same cycle. On a hit it returns the physical address one cycle later. The physical address is the stored physical page number joined to the untouched 12-bit page offset. The block also reports whether the page's dirty status has to be updated in the page tables.

On a miss the block handles the refill in hardware. It raises a request to an external page walker and waits for the walker's answer. It writes the returned translation into the slot named by a rotating victim pointer, then repeats the lookup, which now hits. If the walker reports a fault, nothing is stored and the pending lookup ends with a fault response. A flush input empties the whole structure in one cycle.

Top module: `xlat_cache`

## Requirements
- R1: A lookup accepted at a clock edge that hits gives `resp_valid_o`=1 in the following cycle, with `resp_hit_o`=1, `resp_fault_o`=0 and `resp_paddr_o` = {stored page number, `req_vaddr_i[11:0]`}.
- R2: A lookup that misses raises `walk_req_o` in the cycle after acceptance, with `walk_vpn_o` = `req_vaddr_i[31:12]`. Both hold until the edge at which `walk_ack_i` is seen high.
- R3: After a walker answer with `walk_fault_i`=0, the translation is stored and the lookup is repeated in the next cycle. The response then appears one cycle later still, with `resp_hit_o`=0, `resp_fault_o`=0 and `resp_paddr_o` = {`walk_ppn_i`, offset}.
- R4: Refills go to slots 0, 1, 2, … in order, wrapping from 31 back to 0. The 33rd distinct refill therefore evicts the page stored by the 1st.
- R5: All 32 slots are searched in parallel and any page may occupy any slot. Thirty-two pages that agree in all low page-number bits all hit together.
- R6: A write lookup that hits an entry whose dirty flag is clear returns `resp_set_dirty_o`=1 and sets that flag. Later writes to the same page, and all reads, return `resp_set_dirty_o`=0.
- R7: The `walk_dirty_i` value given at refill is stored as the entry's dirty flag. A write refilled with `walk_dirty_i`=1 returns `resp_set_dirty_o`=0.
- R8: A cycle with `flush_i`=1 invalidates every entry and returns the victim pointer to slot 0 at the next edge. Any refill answer at that same edge is dropped.
- R9: A walker answer with `walk_fault_i`=1 stores nothing and leaves the victim pointer unchanged. It gives a response in the next cycle with `resp_fault_o`=1 and `resp_hit_o`=0.
- R10: `req_ready_o` is 1 only while no lookup is pending and `flush_i` is 0. A request is accepted only at an edge where `req_ready_o` is 1. After reset `req_ready_o`=1, `resp_valid_o`=0 and `walk_req_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request present |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Lookup is for a write |
| req_ready_o | output | 1 | Request accepted at this edge if valid |
| resp_valid_o | output | 1 | Response present (one-cycle pulse) |
| resp_hit_o | output | 1 | Served without a refill |
| resp_fault_o | output | 1 | Walker reported a fault |
| resp_set_dirty_o | output | 1 | Page must be marked dirty in the page tables |
| resp_paddr_o | output | 32 | Translated physical address |
| walk_req_o | output | 1 | Refill request to the page walker |
| walk_vpn_o | output | 20 | Page number to walk |
| walk_ack_i | input | 1 | Walker answer present |
| walk_ppn_i | input | 20 | Physical page number returned |
| walk_dirty_i | input | 1 | Dirty status returned |
| walk_fault_i | input | 1 | Translation does not exist |

## Verification
On every cycle the assertions check several properties. The match vector never holds more than one set bit. The victim pointer advances by exactly one slot with wrap after each refill and returns to zero after a flush. Nothing matches right after a flush. A faulting answer writes nothing and produces a fault response. A dirty-mark decision always reaches the response, and a refilled page is found by the retry. Eviction order over many refills, the exact physical address, the dirty flag carried from the walker, and the acceptance rule around flushes can only be shown by the bench's scenarios. Those scenarios compare every output against a behavioural model on each clock.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int XC_VA_W    = 32;
  localparam int XC_PA_W    = 32;
  localparam int XC_OFS_W   = 12;
  localparam int XC_ENTRIES = 32;

  typedef enum logic [1:0] {
    XC_IDLE  = 2'd0,
    XC_WALK  = 2'd1,
    XC_RETRY = 2'd2
  } xc_state_e;
endpackage

// File: rtl/xc_entry_array.sv
module xc_entry_array #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic [VPN_W-1:0]   look_vpn_i,
  input  logic               fill_en_i,
  input  logic [IDX_W-1:0]   fill_idx_i,
  input  logic [VPN_W-1:0]   fill_vpn_i,
  input  logic [PPN_W-1:0]   fill_ppn_i,
  input  logic               fill_dirty_i,
  input  logic               mark_en_i,
  output logic [ENTRIES-1:0] hit_vec_o,
  output logic               hit_o,
  output logic [PPN_W-1:0]   hit_ppn_o,
  output logic               hit_dirty_o
);
  logic [ENTRIES-1:0][PPN_W-1:0] sel_ppn;
  logic [ENTRIES-1:0]            sel_dirty;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             val_q;
    logic             dty_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic             match;

    assign match        = val_q && (vpn_q == look_vpn_i);
    assign hit_vec_o[g] = match;
    assign sel_ppn[g]   = match ? ppn_q : '0;
    assign sel_dirty[g] = match & dty_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= 1'b0;
        dty_q <= 1'b0;
        vpn_q <= '0;
        ppn_q <= '0;
      end else if (flush_i) begin
        val_q <= 1'b0;
      end else if (fill_en_i && (fill_idx_i == IDX_W'(g))) begin
        val_q <= 1'b1;
        dty_q <= fill_dirty_i;
        vpn_q <= fill_vpn_i;
        ppn_q <= fill_ppn_i;
      end else if (mark_en_i && match) begin
        dty_q <= 1'b1;
      end
    end
  end

  always_comb begin
    hit_ppn_o = '0;
    for (int i = 0; i < ENTRIES; i++) hit_ppn_o |= sel_ppn[i];
  end

  assign hit_o       = |hit_vec_o;
  assign hit_dirty_o = |sel_dirty;
endmodule

// File: rtl/xc_victim_ptr.sv
module xc_victim_ptr #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr_o <= '0;
    else if (flush_i) ptr_o <= '0;
    else if (adv_i)   ptr_o <= wrap_inc(ptr_o);
  end
endmodule

// File: rtl/xc_ctrl.sv
module xc_ctrl
  import xc_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFS_W = 12,
  parameter int VPN_W = VA_W - OFS_W,
  parameter int PPN_W = PA_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic             hit_i,
  input  logic [PPN_W-1:0] hit_ppn_i,
  input  logic             hit_dirty_i,
  input  logic             walk_ack_i,
  input  logic             walk_fault_i,
  output logic             ready_o,
  output logic [VPN_W-1:0] look_vpn_o,
  output logic             fill_en_o,
  output logic             mark_en_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  output logic             resp_valid_o,
  output logic             resp_hit_o,
  output logic             resp_fault_o,
  output logic             resp_set_dirty_o,
  output logic [PA_W-1:0]  resp_paddr_o
);
  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                              input logic [VA_W-1:0]  va);
    return {ppn, va[OFS_W-1:0]};
  endfunction

  function automatic logic [VPN_W-1:0] page_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFS_W];
  endfunction

  xc_state_e        state_q, state_d;
  logic [VA_W-1:0]  hold_va_q;
  logic             hold_wr_q;
  logic [VA_W-1:0]  look_va;
  logic             look_wr;
  logic             accept, retry_go, probe, probe_hit, fault_ack;

  assign look_va   = (state_q == XC_IDLE) ? req_vaddr_i : hold_va_q;
  assign look_wr   = (state_q == XC_IDLE) ? req_write_i : hold_wr_q;
  assign ready_o   = (state_q == XC_IDLE) && !flush_i;
  assign accept    = ready_o && req_valid_i;
  assign retry_go  = (state_q == XC_RETRY) && !flush_i;
  assign probe     = accept || retry_go;
  assign probe_hit = probe && hit_i;
  assign fault_ack = (state_q == XC_WALK) && walk_ack_i && walk_fault_i;

  assign look_vpn_o = page_of(look_va);
  assign mark_en_o  = probe_hit && look_wr && !hit_dirty_i;
  assign fill_en_o  = (state_q == XC_WALK) && walk_ack_i && !walk_fault_i && !flush_i;
  assign walk_req_o = (state_q == XC_WALK);
  assign walk_vpn_o = page_of(hold_va_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XC_IDLE:  if (accept && !hit_i) state_d = XC_WALK;
      XC_WALK:  if (walk_ack_i) state_d = walk_fault_i ? XC_IDLE : XC_RETRY;
      XC_RETRY: if (retry_go) state_d = hit_i ? XC_IDLE : XC_WALK;
      default:  state_d = XC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q          <= XC_IDLE;
      hold_va_q        <= '0;
      hold_wr_q        <= 1'b0;
      resp_valid_o     <= 1'b0;
      resp_hit_o       <= 1'b0;
      resp_fault_o     <= 1'b0;
      resp_set_dirty_o <= 1'b0;
      resp_paddr_o     <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        hold_va_q <= req_vaddr_i;
        hold_wr_q <= req_write_i;
      end
      resp_valid_o     <= probe_hit || fault_ack;
      resp_hit_o       <= accept && hit_i;
      resp_fault_o     <= fault_ack;
      resp_set_dirty_o <= mark_en_o;
      resp_paddr_o     <= probe_hit ? join_pa(hit_ppn_i, look_va) : '0;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int VA_W    = XC_VA_W,
  parameter int PA_W    = XC_PA_W,
  parameter int OFS_W   = XC_OFS_W,
  parameter int ENTRIES = XC_ENTRIES,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  output logic             req_ready_o,
  output logic             resp_valid_o,
  output logic             resp_hit_o,
  output logic             resp_fault_o,
  output logic             resp_set_dirty_o,
  output logic [PA_W-1:0]  resp_paddr_o,
  output logic             walk_req_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  input  logic             walk_ack_i,
  input  logic [PPN_W-1:0] walk_ppn_i,
  input  logic             walk_dirty_i,
  input  logic             walk_fault_i
);
  logic [ENTRIES-1:0] hit_vec;
  logic               look_hit;
  logic [PPN_W-1:0]   look_ppn;
  logic               look_dirty;
  logic [VPN_W-1:0]   look_vpn;
  logic               fill_en;
  logic               mark_en;
  logic [IDX_W-1:0]   victim_ptr;

  xc_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .look_vpn_i(look_vpn),
    .fill_en_i(fill_en), .fill_idx_i(victim_ptr),
    .fill_vpn_i(walk_vpn_o), .fill_ppn_i(walk_ppn_i), .fill_dirty_i(walk_dirty_i),
    .mark_en_i(mark_en),
    .hit_vec_o(hit_vec), .hit_o(look_hit), .hit_ppn_o(look_ppn), .hit_dirty_o(look_dirty)
  );

  xc_victim_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .adv_i(fill_en), .ptr_o(victim_ptr)
  );

  xc_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_write_i(req_write_i),
    .hit_i(look_hit), .hit_ppn_i(look_ppn), .hit_dirty_i(look_dirty),
    .walk_ack_i(walk_ack_i), .walk_fault_i(walk_fault_i),
    .ready_o(req_ready_o), .look_vpn_o(look_vpn),
    .fill_en_o(fill_en), .mark_en_o(mark_en),
    .walk_req_o(walk_req_o), .walk_vpn_o(walk_vpn_o),
    .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .resp_fault_o(resp_fault_o),
    .resp_set_dirty_o(resp_set_dirty_o), .resp_paddr_o(resp_paddr_o)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               look_hit,
  input logic               fill_en,
  input logic               mark_en,
  input logic [IDX_W-1:0]   victim_ptr,
  input logic               req_ready_o,
  input logic               walk_req_o,
  input logic               walk_ack_i,
  input logic               walk_fault_i,
  input logic               resp_valid_o,
  input logic               resp_fault_o,
  input logic               resp_set_dirty_o
);
  // R5: no page is ever held twice
  p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_rr_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> victim_ptr == (($past(victim_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(victim_ptr) + 1'b1));

  p_flush_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> victim_ptr == '0);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> hit_vec == '0);

  p_fault_nofill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_o && walk_ack_i && walk_fault_i) |-> !fill_en);

  p_fault_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_o && walk_ack_i && walk_fault_i) |=> (resp_valid_o && resp_fault_o));

  p_dirty_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_en |=> (resp_valid_o && resp_set_dirty_o));

  p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o |-> !req_ready_o);

  p_fill_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> look_hit);
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
  .hit_vec(hit_vec), .look_hit(look_hit), .fill_en(fill_en), .mark_en(mark_en),
  .victim_ptr(victim_ptr), .req_ready_o(req_ready_o), .walk_req_o(walk_req_o),
  .walk_ack_i(walk_ack_i), .walk_fault_i(walk_fault_i),
  .resp_valid_o(resp_valid_o), .resp_fault_o(resp_fault_o),
  .resp_set_dirty_o(resp_set_dirty_o)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int NSLOT = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_ready_o, resp_valid_o, resp_hit_o, resp_fault_o, resp_set_dirty_o;
  logic [31:0] resp_paddr_o;
  logic        walk_req_o;
  logic [19:0] walk_vpn_o;
  logic        walk_ack_i = 1'b0;
  logic [19:0] walk_ppn_i = '0;
  logic        walk_dirty_i = 1'b0;
  logic        walk_fault_i = 1'b0;

  xlat_cache u_xlat_cache (.*);

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string cur_tag = "R1";

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // page walker stand-in
  bit          cfg_dirty = 0;
  bit          cfg_fault_en = 0;
  logic [19:0] cfg_fault_vpn = '0;
  int          wk_cnt = 0;

  function automatic logic [19:0] map_ppn(input logic [19:0] vpn);
    return vpn ^ 20'hC3A5F;
  endfunction

  always @(negedge clk) begin
    if (walk_req_o && !walk_ack_i) begin
      if (wk_cnt == 2) begin
        walk_ack_i   = 1'b1;
        walk_ppn_i   = map_ppn(walk_vpn_o);
        walk_dirty_i = cfg_dirty;
        walk_fault_i = cfg_fault_en && (walk_vpn_o == cfg_fault_vpn);
        wk_cnt = 0;
      end else begin
        wk_cnt++;
      end
    end else begin
      walk_ack_i   = 1'b0;
      walk_fault_i = 1'b0;
    end
  end

  // behavioural reference model
  int          m_state = 0;
  logic [19:0] m_vpn [NSLOT];
  logic [19:0] m_ppn [NSLOT];
  bit          m_val [NSLOT];
  bit          m_dty [NSLOT];
  int          m_ptr = 0;
  logic [31:0] m_va = '0;
  bit          m_wr = 0;
  bit e_rv = 0, e_hit = 0, e_fault = 0, e_sd = 0;
  logic [31:0] e_pa = '0;

  function automatic int find_page(input logic [19:0] vpn);
    for (int i = 0; i < NSLOT; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic model_probe(input bit first);
    int k;
    k = find_page(m_va[31:12]);
    if (k >= 0) begin
      e_rv = 1; e_hit = first; e_pa = {m_ppn[k], m_va[11:0]};
      if (m_wr && !m_dty[k]) begin e_sd = 1; m_dty[k] = 1; end
      m_state = 0;
    end else begin
      m_state = 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_state = 0; m_ptr = 0;
      for (int i = 0; i < NSLOT; i++) begin m_val[i] = 0; m_dty[i] = 0; end
      e_rv = 0; e_hit = 0; e_fault = 0; e_sd = 0; e_pa = '0;
    end else begin
      e_rv = 0; e_hit = 0; e_fault = 0; e_sd = 0; e_pa = '0;
      case (m_state)
        0: if (req_valid_i && !flush_i) begin
             m_va = req_vaddr_i; m_wr = req_write_i; model_probe(1);
           end
        1: if (walk_ack_i) begin
             if (walk_fault_i) begin e_rv = 1; e_fault = 1; m_state = 0; end
             else begin
               if (!flush_i) begin
                 m_val[m_ptr] = 1; m_vpn[m_ptr] = m_va[31:12];
                 m_ppn[m_ptr] = walk_ppn_i; m_dty[m_ptr] = walk_dirty_i;
                 m_ptr = (m_ptr + 1) % NSLOT;
               end
               m_state = 2;
             end
           end
        default: if (!flush_i) model_probe(0);
      endcase
      if (flush_i) begin
        for (int i = 0; i < NSLOT; i++) m_val[i] = 0;
        m_ptr = 0;
      end
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      check("R10", "ready", req_ready_o, (m_state == 0) && !flush_i);
      check("R2", "walk_req", walk_req_o, m_state == 1);
      if (m_state == 1) check("R2", "walk_vpn", walk_vpn_o, m_va[31:12]);
      check(cur_tag, "resp_valid", resp_valid_o, e_rv);
      if (resp_valid_o && e_rv) begin
        check("R1", "resp_hit", resp_hit_o, e_hit);
        check("R9", "resp_fault", resp_fault_o, e_fault);
        check("R6", "set_dirty", resp_set_dirty_o, e_sd);
        if (!e_fault) check(cur_tag, "paddr", resp_paddr_o, e_pa);
      end
    end
  end

  bit          g_hit, g_fault, g_sd;
  logic [31:0] g_pa;

  task automatic do_lookup(input logic [31:0] va, input bit wr);
    @(negedge clk);
    req_valid_i = 1; req_vaddr_i = va; req_write_i = wr;
    #1;
    while (!req_ready_o) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid_i = 0;
    while (!resp_valid_o) @(negedge clk);
    g_hit = resp_hit_o; g_fault = resp_fault_o; g_sd = resp_set_dirty_o; g_pa = resp_paddr_o;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_i = 1;
    @(negedge clk); flush_i = 0;
  endtask

  function automatic logic [31:0] va_of(input logic [19:0] vpn, input logic [11:0] ofs);
    return {vpn, ofs};
  endfunction

  function automatic logic [19:0] grp_vpn(input int i);
    return {i[4:0], 15'h0155};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R10";
    check("R10", "reset ready", req_ready_o, 1);
    check("R10", "reset resp_valid", resp_valid_o, 0);
    check("R10", "reset walk_req", walk_req_o, 0);

    cur_tag = "R3";
    do_lookup(va_of(20'h12345, 12'h678), 0);
    check("R3", "refill hit flag", g_hit, 0);
    check("R3", "refill paddr", g_pa, va_of(map_ppn(20'h12345), 12'h678));
    cur_tag = "R1";
    do_lookup(va_of(20'h12345, 12'hABC), 0);
    check("R1", "hit flag", g_hit, 1);
    check("R1", "hit paddr", g_pa, va_of(map_ppn(20'h12345), 12'hABC));

    cur_tag = "R6";
    do_lookup(va_of(20'h12345, 12'h004), 1);
    check("R6", "first write marks", g_sd, 1);
    do_lookup(va_of(20'h12345, 12'h008), 1);
    check("R6", "second write quiet", g_sd, 0);
    do_lookup(va_of(20'h12345, 12'h00C), 0);
    check("R6", "read quiet", g_sd, 0);

    cur_tag = "R7";
    cfg_dirty = 1;
    do_lookup(va_of(20'h0BEEF, 12'h010), 1);
    check("R7", "walker dirty kept", g_sd, 0);
    cfg_dirty = 0;

    cur_tag = "R9";
    cfg_fault_en = 1; cfg_fault_vpn = 20'h00777;
    do_lookup(va_of(20'h00777, 12'h000), 0);
    check("R9", "fault flag", g_fault, 1);
    check("R9", "fault hit", g_hit, 0);
    do_lookup(va_of(20'h00777, 12'h000), 0);
    check("R9", "nothing stored", g_fault, 1);
    cfg_fault_en = 0;

    cur_tag = "R10";
    @(negedge clk);
    req_valid_i = 1; req_vaddr_i = va_of(20'h12345, 12'h100); req_write_i = 0; flush_i = 1;
    #1;
    check("R10", "ready low in flush", req_ready_o, 0);
    @(negedge clk);
    flush_i = 0;
    #1;
    check("R10", "ready back", req_ready_o, 1);
    @(negedge clk);
    req_valid_i = 0;
    while (!resp_valid_o) @(negedge clk);
    check("R8", "miss after flush", resp_hit_o, 0);

    cur_tag = "R5";
    do_flush();
    for (int i = 0; i < NSLOT; i++) do_lookup(va_of(grp_vpn(i), 12'h2F0), 0);
    for (int i = 0; i < NSLOT; i++) begin
      do_lookup(va_of(grp_vpn(i), 12'h2F4), 0);
      check("R5", "all slots hit", g_hit, 1);
    end

    cur_tag = "R4";
    do_lookup(va_of(20'hFFFFF, 12'h001), 0);
    check("R4", "33rd refill", g_hit, 0);
    do_lookup(va_of(grp_vpn(1), 12'h001), 0);
    check("R4", "second page kept", g_hit, 1);
    do_lookup(va_of(grp_vpn(0), 12'h001), 0);
    check("R4", "first page evicted", g_hit, 0);

    cur_tag = "R8";
    do_flush();
    do_lookup(va_of(grp_vpn(1), 12'h001), 0);
    check("R8", "flushed entry misses", g_hit, 0);
    do_lookup(va_of(grp_vpn(1), 12'h001), 0);
    check("R8", "refilled after flush", g_hit, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule